// File: doc/BRIEF.md
# Flow Steering Hash Engine

This block computes the two 16-bit hashes that a flow-steering filter table needs for a flow. One hash picks the table bucket and the other tags the entry. The flow key is eleven 32-bit words. Word 0 carries the flow-type, pool and packet-type bits. Words 1 to 10 carry the addresses and ports. Each hash is an XOR fold of the key that is gated bit by bit by a 32-bit programmable hash key. The bucket hash and the signature hash use the same fold with different hash keys, and the two run in parallel.

The bucket hash is masked down to an index. The width of the index follows a 2-bit buffer-size select. The block also produces a packed 32-bit word for the filter command. The bucket index sits in the low half. The high half holds the signature, or, in perfect-match mode, a software filter index in place of the signature.

The block is a two-stage pipeline with a start strobe and a done strobe. It accepts a new key on every cycle. Packet parsing and filter storage are outside the block.

Top module: `flow_hash_engine`

## Requirements
- R1: While reset is held and in the first cycle after it, `done` is low and `bucket_idx`, `signature` and `packed_hash` are all zero.
- R2: Each cycle with `start` high produces exactly one cycle with `done` high, two clock edges later. Starts on consecutive cycles produce dones on consecutive cycles, in the same order. No `done` appears without a start.
- R3: Let hi be the XOR of key words 1..10, and lo be hi with its 16-bit halves swapped. Let hm = hi ^ w0 ^ (w0 >> 16) and lm = lo ^ w0 ^ (w0 << 16). The keyed hash XORs together these terms: lo if hash-key bit 0 is set, and lm >> i for each set bit i in 1..15. For each set bit 16+i with i in 0..15, it also adds hm >> i. The hash is the low 16 bits of that sum. `signature` is this hash under `sig_key`.
- R4: `bucket_idx` is the R3 hash under `bucket_key`, with only its low N bits kept. N is 13 for `buf_sel` = 0, 14 for 1 and 15 for 2. The reserved code 3 behaves as 0.
- R5: With a hash key of 0x00000001, word 0 has no effect on the hash.
- R6: Words 1..10 enter only through their XOR, so swapping any two of them leaves every output unchanged.
- R7: `packed_hash[15:0]` equals `bucket_idx`. `packed_hash[31:16]` equals `signature` when `perfect_mode` is 0, and the zero-extended `filter_idx` when `perfect_mode` is 1.
- R8: In cycles where `done` is low, all three result outputs keep their previous values.
- R9: A zero hash key gives a zero hash. An all-zero flow key gives zero under any hash key.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Accept the key and settings on this edge |
| key_words | input | 352 | Flow key; word k at bits [32k+31:32k] |
| bucket_key | input | 32 | Hash key for the bucket hash |
| sig_key | input | 32 | Hash key for the signature hash |
| buf_sel | input | 2 | Buffer-size select for the bucket mask |
| perfect_mode | input | 1 | 1: filter index replaces signature in the packed word |
| filter_idx | input | 16 | Software filter index for perfect-match mode |
| done | output | 1 | Results valid this cycle |
| bucket_idx | output | 16 | Masked bucket index |
| signature | output | 16 | Signature hash |
| packed_hash | output | 32 | Packed command word |

## Verification
The main hazard is the deferred mixing of word 0. Key bit 0 must see the unmixed swapped word while key bits 1..15 see the mixed one. A design that mixes word 0 in too early fails the single-bit-key case with a nonzero word 0. A design that shifts the wrong half gives wrong upper hash bits under the all-ones key. Mask-width errors show up as stray bucket bits for each buffer code, including the reserved one. Back-to-back starts with differing settings catch stage-one settings that are not carried along with their key, which would show up as a packed word taking its mode or index from a neighbouring request.

// File: rtl/fsh_pkg.sv
// Shared definitions for the flow steering hash engine.
// Assumes nothing beyond the parameters passed by its users.
package fsh_pkg;

    // Buffer-size select codes; the reserved code maps to the smallest mask.
    typedef enum logic [1:0] {
        BUF_SMALL = 2'd0,
        BUF_MID   = 2'd1,
        BUF_LARGE = 2'd2,
        BUF_RSVD  = 2'd3
    } buf_sel_e;

    // Number of bucket bits kept for a select code on top of a base width.
    function automatic int unsigned bucket_width(input logic [1:0] sel,
                                                 input int unsigned base_w);
        case (buf_sel_e'(sel))
            BUF_MID:   return base_w + 1;
            BUF_LARGE: return base_w + 2;
            default:   return base_w;
        endcase
    endfunction

endpackage

// File: rtl/fsh_fold.sv
// Folds the flow key: XOR of words 1..NUM_WORDS-1 into a common word,
// and passes word 0 (the flow/pool/type seed) out separately.
// Assumes word k occupies bits [k*WORD_W +: WORD_W] of the flat key.
module fsh_fold #(
    parameter int unsigned NUM_WORDS = 11,
    parameter int unsigned WORD_W    = 32,
    localparam int unsigned KEY_W    = NUM_WORDS * WORD_W
) (
    input  logic [KEY_W-1:0]  key_flat,
    output logic [WORD_W-1:0] common,
    output logic [WORD_W-1:0] seed
);

    // XOR-reduce every word except the seed word.
    always_comb begin
        common = '0;
        for (int k = 1; k < NUM_WORDS; k++) begin
            common = common ^ key_flat[k*WORD_W +: WORD_W];
        end
    end

    // Word 0 is mixed in later by the keyed hash.
    assign seed = key_flat[WORD_W-1:0];

endmodule

// File: rtl/fsh_keyed_hash.sv
// Keyed XOR hash of a folded flow key.
// Low hash-key bits gate shifted copies of the half-swapped common word,
// high hash-key bits gate shifted copies of the common word; the seed is
// mixed into both, except into the term selected by hash-key bit 0.
// Assumes WORD_W is even and HASH_W <= WORD_W.
module fsh_keyed_hash #(
    parameter int unsigned WORD_W = 32,
    parameter int unsigned HASH_W = 16,
    localparam int unsigned HALF  = WORD_W / 2
) (
    input  logic [WORD_W-1:0] common,
    input  logic [WORD_W-1:0] seed,
    input  logic [WORD_W-1:0] hkey,
    output logic [HASH_W-1:0] hash
);

    logic [WORD_W-1:0] lo_base;
    logic [WORD_W-1:0] lo_mix;
    logic [WORD_W-1:0] hi_mix;
    logic [WORD_W-1:0] term [HALF];

    // Derive the swapped and seed-mixed variants of the common word.
    always_comb begin
        lo_base = {common[HALF-1:0], common[WORD_W-1:HALF]};
        hi_mix  = common ^ seed ^ (seed >> HALF);
        lo_mix  = lo_base ^ seed ^ (seed << HALF);
    end

    // One term per hash-key bit pair; bit 0 sees the unmixed swapped word.
    for (genvar i = 0; i < HALF; i++) begin : g_term
        if (i == 0) begin : g_first
            assign term[i] = (hkey[0] ? lo_base : '0)
                           ^ (hkey[HALF] ? hi_mix : '0);
        end else begin : g_rest
            assign term[i] = (hkey[i] ? (lo_mix >> i) : '0)
                           ^ (hkey[i+HALF] ? (hi_mix >> i) : '0);
        end
    end

    // XOR all terms and keep the hash width.
    always_comb begin
        logic [WORD_W-1:0] acc;
        acc = '0;
        for (int i = 0; i < HALF; i++) begin
            acc = acc ^ term[i];
        end
        hash = acc[HASH_W-1:0];
    end

endmodule

// File: rtl/fsh_bucket_mask.sv
// Keeps the low bucket bits of a hash, the count chosen by buffer size.
// Assumes BASE_W + 2 <= HASH_W.
module fsh_bucket_mask #(
    parameter int unsigned HASH_W = 16,
    parameter int unsigned BASE_W = 13
) (
    input  logic [1:0]        buf_sel,
    input  logic [HASH_W-1:0] raw,
    output logic [HASH_W-1:0] masked
);
    import fsh_pkg::*;

    // Build the mask from the selected width and apply it.
    always_comb begin
        int unsigned w;
        logic [HASH_W-1:0] m;
        w = bucket_width(buf_sel, BASE_W);
        m = {HASH_W{1'b1}} >> (HASH_W - w);
        masked = raw & m;
    end

endmodule

// File: rtl/flow_hash_engine.sv
// Flow steering hash engine, two pipeline stages.
// Stage 1 folds the key and captures the settings; stage 2 runs the bucket
// and signature hashes in parallel, masks, packs and registers the results.
// Assumes IDX_W <= HASH_W and that start may be high on every cycle.
module flow_hash_engine #(
    parameter int unsigned NUM_WORDS = 11,
    parameter int unsigned WORD_W    = 32,
    parameter int unsigned HASH_W    = 16,
    parameter int unsigned BASE_W    = 13,
    parameter int unsigned IDX_W     = 16,
    localparam int unsigned KEY_W    = NUM_WORDS * WORD_W,
    localparam int unsigned PACK_W   = 2 * HASH_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [KEY_W-1:0]  key_words,
    input  logic [WORD_W-1:0] bucket_key,
    input  logic [WORD_W-1:0] sig_key,
    input  logic [1:0]        buf_sel,
    input  logic              perfect_mode,
    input  logic [IDX_W-1:0]  filter_idx,
    output logic              done,
    output logic [HASH_W-1:0] bucket_idx,
    output logic [HASH_W-1:0] signature,
    output logic [PACK_W-1:0] packed_hash
);

    logic [WORD_W-1:0] fold_common;
    logic [WORD_W-1:0] fold_seed;

    logic              s1_valid;
    logic [WORD_W-1:0] s1_common;
    logic [WORD_W-1:0] s1_seed;
    logic [WORD_W-1:0] s1_bkey;
    logic [WORD_W-1:0] s1_skey;
    logic [1:0]        s1_sel;
    logic              s1_perf;
    logic [IDX_W-1:0]  s1_idx;

    logic [HASH_W-1:0] bkt_raw;
    logic [HASH_W-1:0] bkt_masked;
    logic [HASH_W-1:0] sig_raw;
    logic [HASH_W-1:0] upper_field;

    fsh_fold #(
        .NUM_WORDS (NUM_WORDS),
        .WORD_W    (WORD_W)
    ) i_fold (
        .key_flat (key_words),
        .common   (fold_common),
        .seed     (fold_seed)
    );

    // Stage 1: capture the folded key and the settings that go with it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid  <= 1'b0;
            s1_common <= '0;
            s1_seed   <= '0;
            s1_bkey   <= '0;
            s1_skey   <= '0;
            s1_sel    <= '0;
            s1_perf   <= 1'b0;
            s1_idx    <= '0;
        end else begin
            s1_valid <= start;
            if (start) begin
                s1_common <= fold_common;
                s1_seed   <= fold_seed;
                s1_bkey   <= bucket_key;
                s1_skey   <= sig_key;
                s1_sel    <= buf_sel;
                s1_perf   <= perfect_mode;
                s1_idx    <= filter_idx;
            end
        end
    end

    fsh_keyed_hash #(
        .WORD_W (WORD_W),
        .HASH_W (HASH_W)
    ) i_bkt_hash (
        .common (s1_common),
        .seed   (s1_seed),
        .hkey   (s1_bkey),
        .hash   (bkt_raw)
    );

    fsh_keyed_hash #(
        .WORD_W (WORD_W),
        .HASH_W (HASH_W)
    ) i_sig_hash (
        .common (s1_common),
        .seed   (s1_seed),
        .hkey   (s1_skey),
        .hash   (sig_raw)
    );

    fsh_bucket_mask #(
        .HASH_W (HASH_W),
        .BASE_W (BASE_W)
    ) i_mask (
        .buf_sel (s1_sel),
        .raw     (bkt_raw),
        .masked  (bkt_masked)
    );

    // Choose what goes in the upper half of the packed word.
    assign upper_field = s1_perf ? HASH_W'(s1_idx) : sig_raw;

    // Stage 2: register results; hold them between valid computations.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done        <= 1'b0;
            bucket_idx  <= '0;
            signature   <= '0;
            packed_hash <= '0;
        end else begin
            done <= s1_valid;
            if (s1_valid) begin
                bucket_idx  <= bkt_masked;
                signature   <= sig_raw;
                packed_hash <= {upper_field, bkt_masked};
            end
        end
    end

endmodule

// File: rtl/flow_hash_engine_chk.sv
// Property checker for flow_hash_engine, attached by bind.
// Tracks cycles since reset so that history-based checks start only once
// enough post-reset history exists.
module flow_hash_engine_chk #(
    parameter int unsigned HASH_W = 16,
    parameter int unsigned BASE_W = 13,
    parameter int unsigned IDX_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic [1:0]        buf_sel,
    input logic              perfect_mode,
    input logic [IDX_W-1:0]  filter_idx,
    input logic              done,
    input logic [HASH_W-1:0] bucket_idx,
    input logic [HASH_W-1:0] signature,
    input logic [2*HASH_W-1:0] packed_hash
);
    import fsh_pkg::*;

    logic [1:0] age_q;

    // Saturating count of cycles since reset release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            age_q <= '0;
        end else if (age_q != 2'd3) begin
            age_q <= age_q + 2'd1;
        end
    end

    p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q >= 2'd2) |-> (done == $past(start, 2)))
        else $error("R2 done not two cycles after start");

    p_bucket_mask_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q >= 2'd2 && done) |->
            ((bucket_idx >> bucket_width($past(buf_sel, 2), BASE_W)) == '0))
        else $error("R4 bucket bits above mask width");

    p_packed_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (packed_hash[HASH_W-1:0] == bucket_idx))
        else $error("R7 packed low half differs from bucket");

    p_packed_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q >= 2'd2 && done) |->
            (packed_hash[2*HASH_W-1:HASH_W] ==
             ($past(perfect_mode, 2) ? HASH_W'($past(filter_idx, 2)) : signature)))
        else $error("R7 packed high half wrong");

    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q >= 2'd1 && !done) |->
            ($stable(bucket_idx) && $stable(signature) && $stable(packed_hash)))
        else $error("R8 outputs moved without done");

endmodule

bind flow_hash_engine flow_hash_engine_chk #(
    .HASH_W (HASH_W),
    .BASE_W (BASE_W),
    .IDX_W  (IDX_W)
) i_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (start),
    .buf_sel      (buf_sel),
    .perfect_mode (perfect_mode),
    .filter_idx   (filter_idx),
    .done         (done),
    .bucket_idx   (bucket_idx),
    .signature    (signature),
    .packed_hash  (packed_hash)
);

// File: tb/test_flow_hash_engine.sv
// Scoreboard bench: the driver pushes expected results computed by a
// bit-serial model; the monitor pops and compares them at each done.
module test_flow_hash_engine;

    localparam int NW = 11;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [NW*32-1:0] key_words = '0;
    logic [31:0]   bucket_key = '0;
    logic [31:0]   sig_key = '0;
    logic [1:0]    buf_sel = '0;
    logic          perfect_mode = 1'b0;
    logic [15:0]   filter_idx = '0;
    logic          done;
    logic [15:0]   bucket_idx;
    logic [15:0]   signature;
    logic [31:0]   packed_hash;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    typedef struct {
        int          due;
        logic [15:0] bkt;
        logic [15:0] sig;
        logic [31:0] pk;
        string       tag;
    } exp_t;

    exp_t sb[$];

    always #10 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    flow_hash_engine i_flow_hash_engine (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (start),
        .key_words    (key_words),
        .bucket_key   (bucket_key),
        .sig_key      (sig_key),
        .buf_sel      (buf_sel),
        .perfect_mode (perfect_mode),
        .filter_idx   (filter_idx),
        .done         (done),
        .bucket_idx   (bucket_idx),
        .signature    (signature),
        .packed_hash  (packed_hash)
    );

    // Bit-serial model: each result bit built from the R3 definition.
    function automatic logic [15:0] ref_hash(input logic [NW*32-1:0] kw,
                                             input logic [31:0] hk);
        logic [31:0] w0, hi, lo, hm, lm;
        logic [15:0] r;
        w0 = kw[31:0];
        hi = '0;
        for (int k = 1; k < NW; k++) hi = hi ^ kw[k*32 +: 32];
        lo = {hi[15:0], hi[31:16]};
        hm = hi ^ w0 ^ (w0 >> 16);
        lm = lo ^ w0 ^ (w0 << 16);
        for (int b = 0; b < 16; b++) begin
            logic bit_v;
            bit_v = 1'b0;
            if (hk[0]) bit_v = bit_v ^ lo[b];
            for (int i = 1; i < 16; i++)
                if (hk[i]) bit_v = bit_v ^ lm[b+i];
            for (int i = 0; i < 16; i++)
                if (hk[16+i]) bit_v = bit_v ^ hm[b+i];
            r[b] = bit_v;
        end
        return r;
    endfunction

    function automatic void check(input bit ok, input string tag,
                                  input string what, input logic [31:0] act,
                                  input logic [31:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, expv);
        end
    endfunction

    // Driver: present one request at this negedge and push its expectation.
    task automatic issue(input logic [NW*32-1:0] kw, input logic [31:0] bk,
                         input logic [31:0] sk, input logic [1:0] sel,
                         input logic perf, input logic [15:0] idx,
                         input string tag);
        exp_t e;
        int n;
        logic [15:0] bh;
        n = (sel == 2'd1) ? 14 : (sel == 2'd2) ? 15 : 13;
        bh = ref_hash(kw, bk) & ((16'h1 << n) - 16'h1);
        e.due = cyc + 2;
        e.bkt = bh;
        e.sig = ref_hash(kw, sk);
        e.pk  = {perf ? idx : e.sig, bh};
        e.tag = tag;
        sb.push_back(e);
        key_words = kw; bucket_key = bk; sig_key = sk;
        buf_sel = sel; perfect_mode = perf; filter_idx = idx;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Monitor: compare each done against the scoreboard head, and hold (R8).
    logic [15:0] last_b = '0, last_s = '0;
    logic [31:0] last_p = '0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (done) begin
                if (sb.size() == 0) begin
                    check(1'b0, "R2", "done without start", 32'(done), 32'h0);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    check(e.due == cyc, "R2", "done cycle", 32'(cyc), 32'(e.due));
                    check(bucket_idx == e.bkt, e.tag, "bucket", 32'(bucket_idx), 32'(e.bkt));
                    check(signature == e.sig, e.tag, "signature", 32'(signature), 32'(e.sig));
                    check(packed_hash == e.pk, e.tag, "packed (R7)", packed_hash, e.pk);
                end
            end else begin
                if (sb.size() != 0 && sb[0].due <= cyc) begin
                    exp_t e;
                    e = sb.pop_front();
                    check(1'b0, "R2", "missing done", 32'(cyc), 32'(e.due));
                end
                check({bucket_idx, signature} == {last_b, last_s} && packed_hash == last_p,
                      "R8", "hold", packed_hash, last_p);
            end
            last_b = bucket_idx; last_s = signature; last_p = packed_hash;
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(20 * 100000);
        check(1'b0, "R2", "watchdog expired", 32'(cyc), 32'h0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [NW*32-1:0] kw, kw2;
        repeat (3) @(negedge clk);
        check(done == 1'b0, "R1", "done in reset", 32'(done), 32'h0);
        check(packed_hash == '0 && bucket_idx == '0 && signature == '0,
              "R1", "outputs in reset", packed_hash, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check(done == 1'b0, "R1", "done after reset", 32'(done), 32'h0);
        check(packed_hash == '0, "R1", "packed after reset", packed_hash, 32'h0);

        for (int k = 0; k < NW; k++) kw[k*32 +: 32] = 32'h1357_9BDF * (k + 3) ^ (32'hA5A5_0000 >> k);

        // R3 / R4: each buffer code, including the reserved one.
        for (int s = 0; s < 4; s++) begin
            issue(kw, 32'h3DAD_14E2, 32'h1742_6212, 2'(s), 1'b0, 16'h0, "R4");
            idle(2);
        end
        // R3: all-ones flow key and all-ones hash keys.
        issue({NW*32{1'b1}}, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 2'd2, 1'b0, 16'h0, "R3");
        idle(3);
        // R9: zero flow key; zero hash key.
        issue('0, 32'hFFFF_FFFF, 32'h8421_1248, 2'd2, 1'b0, 16'h0, "R9");
        issue(kw, 32'h0, 32'h0, 2'd2, 1'b0, 16'h0, "R9");
        idle(3);
        check(bucket_idx == 16'h0 && signature == 16'h0, "R9",
              "zero hash key", {bucket_idx, signature}, 32'h0);
        // R5: single-bit key, word 0 varied; the model must agree too.
        kw2 = kw; kw2[31:0] = 32'hDEAD_BEEF;
        check(ref_hash(kw, 32'h1) == ref_hash(kw2, 32'h1), "R5", "model word0",
              32'(ref_hash(kw2, 32'h1)), 32'(ref_hash(kw, 32'h1)));
        issue(kw, 32'h1, 32'h1, 2'd2, 1'b0, 16'h0, "R5");
        issue(kw2, 32'h1, 32'h1, 2'd2, 1'b0, 16'h0, "R5");
        // R3: word 0 does matter with other key bits.
        issue(kw2, 32'h0001_0002, 32'h0002_0001, 2'd2, 1'b0, 16'h0, "R3");
        idle(3);
        // R6: swap words 2 and 9.
        kw2 = kw;
        kw2[2*32 +: 32] = kw[9*32 +: 32];
        kw2[9*32 +: 32] = kw[2*32 +: 32];
        issue(kw, 32'h5A5A_C3C3, 32'h0F1E_2D3C, 2'd1, 1'b0, 16'h0, "R6");
        issue(kw2, 32'h5A5A_C3C3, 32'h0F1E_2D3C, 2'd1, 1'b0, 16'h0, "R6");
        idle(3);
        // R7 with R2: back-to-back, mixed modes and indices.
        for (int t = 0; t < 8; t++) begin
            kw2 = kw ^ ({NW{32'(t * 32'h0101_0A0B)}});
            issue(kw2, 32'h3DAD_14E2 ^ 32'(t), 32'h1742_6212 << t, 2'(t),
                  1'(t & 1), 16'(16'hBEE0 + t), "R7");
        end
        idle(4);
        check(sb.size() == 0, "R2", "scoreboard drained", 32'(sb.size()), 32'h0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule